// File: doc/BRIEF.md
# Timer Output Compare Unit

This block watches a free-running timer and compares its value with a compare value that software has loaded. When the two become equal, the block carries out the action picked by a 4-bit mode code. It can force an output pin high or low. It can set only an interrupt flag and leave the pin alone. It can also raise a special event trigger. The timer, the converter and the register decode all sit outside the block. The block only reads the timer and compare values and drives pulse and level outputs back out.

A match counts once, on the first clock in which equality is seen. Equality that lasts several clocks does not fire again. All outputs are registered, so each action shows at the clock edge where the match is sampled. The special event trigger sends a one-cycle timer-clear request. It also sends a one-cycle converter-start pulse, but only in instances built as the converter channel. The timer logic outside must treat the clear request as a load, so it does not count as an overflow. There is no streaming data path, so every port is a plain level or pulse with no handshake.

Top module: `ocmp_unit`

## Requirements
- R1: While reset is asserted (rst_n low), pin_out, cmp_flag, tmr_clr and adc_start are all 0.
- R2: Only mode codes 4'b1000 to 4'b1011 arm the comparator. Under any other code (for example 4'b0000 or 4'b1100), equality neither sets cmp_flag nor pulses tmr_clr nor moves pin_out.
- R3: A match fires only in a clock where tmr_val equals cmp_val and did not equal it in the previous clock. Equality held over several clocks fires once.
- R4: In mode 4'b1000, a match drives pin_out to 1 at the clock edge that samples it.
- R5: In mode 4'b1001, a match drives pin_out to 0 at the clock edge that samples it.
- R6: In mode 4'b1010, a match sets cmp_flag and leaves pin_out unchanged.
- R7: In mode 4'b1011, a match sets cmp_flag, leaves pin_out unchanged and raises tmr_clr for exactly one clock.
- R8: When ADC_CH is 1, adc_start pulses together with every tmr_clr pulse. When ADC_CH is 0, adc_start stays 0.
- R9: Any match sets cmp_flag, and cmp_flag holds until flag_clr is seen. When a match and flag_clr arrive in the same clock, the flag ends up set.
- R10: When mode changes to 4'b1000, pin_out is preset to 0 at the next clock edge. When mode changes to 4'b1001, pin_out is preset to 1. A match in that same clock overrides the preset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_val | input | TMR_W | Current timer count |
| cmp_val | input | TMR_W | Compare value |
| mode | input | 4 | Action code |
| flag_clr | input | 1 | Flag clear strobe |
| pin_out | output | 1 | Compare output pin level |
| cmp_flag | output | 1 | Sticky compare interrupt flag |
| tmr_clr | output | 1 | One-cycle timer clear request |
| adc_start | output | 1 | One-cycle converter start request |

## Verification
The bench builds two instances with TMR_W at 16 that share all inputs. One has ADC_CH set to 1 and the other has ADC_CH set to 0. The pair lets a single special event show the converter pulse on one instance and its absence on the other, while the rest of their outputs match. Random timer values are kept within a few counts of the compare value. This makes new matches, held equality and mode changes in the same clock as a match happen often.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF  = 4'b0000,
    MODE_SET  = 4'b1000,
    MODE_CLR  = 4'b1001,
    MODE_FLAG = 4'b1010,
    MODE_SEV  = 4'b1011
  } ocmp_mode_e;

  // Compare modes occupy the 10xx group of codes.
  function automatic logic mode_armed(input logic [MODE_W-1:0] m);
    return m[MODE_W-1:MODE_W-2] == 2'b10;
  endfunction
endpackage

// File: rtl/ocmp_match_edge.sv
module ocmp_match_edge #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMR_W-1:0] tmr_val,
  input  logic [TMR_W-1:0] cmp_val,
  input  logic             arm,
  output logic             hit
);
  logic eq_now;
  logic eq_prev;

  assign eq_now = (tmr_val == cmp_val);

  always_ff @(posedge clk) begin
    if (!rst_n) eq_prev <= 1'b0;
    else        eq_prev <= eq_now;
  end

  // Fire on the rising edge of equality only.
  assign hit = arm & eq_now & ~eq_prev;
endmodule

// File: rtl/ocmp_pin_ctl.sv
module ocmp_pin_ctl
  import ocmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              hit,
  output logic              pin_out
);
  logic [MODE_W-1:0] mode_prev;
  logic              entered;
  logic              pin_nxt;

  assign entered = (mode != mode_prev);

  always_comb begin
    pin_nxt = pin_out;
    if (entered && mode == MODE_SET) pin_nxt = 1'b0;
    if (entered && mode == MODE_CLR) pin_nxt = 1'b1;
    if (hit && mode == MODE_SET)     pin_nxt = 1'b1;
    if (hit && mode == MODE_CLR)     pin_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_prev <= MODE_OFF;
      pin_out   <= 1'b0;
    end else begin
      mode_prev <= mode;
      pin_out   <= pin_nxt;
    end
  end
endmodule

// File: rtl/ocmp_event_gen.sv
module ocmp_event_gen
  import ocmp_pkg::*;
#(
  parameter bit ADC_CH = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              hit,
  input  logic              flag_clr,
  output logic              cmp_flag,
  output logic              tmr_clr,
  output logic              adc_start
);
  logic sev_hit;
  assign sev_hit = hit & (mode == MODE_SEV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_flag <= 1'b0;
      tmr_clr  <= 1'b0;
    end else begin
      if (hit)           cmp_flag <= 1'b1;
      else if (flag_clr) cmp_flag <= 1'b0;
      tmr_clr <= sev_hit;
    end
  end

  generate
    if (ADC_CH) begin : g_adc
      always_ff @(posedge clk) begin
        if (!rst_n) adc_start <= 1'b0;
        else        adc_start <= sev_hit;
      end
    end else begin : g_no_adc
      assign adc_start = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/ocmp_unit.sv
module ocmp_unit
  import ocmp_pkg::*;
#(
  parameter int TMR_W  = 16,
  parameter bit ADC_CH = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMR_W-1:0] tmr_val,
  input  logic [TMR_W-1:0] cmp_val,
  input  logic [3:0]       mode,
  input  logic             flag_clr,
  output logic             pin_out,
  output logic             cmp_flag,
  output logic             tmr_clr,
  output logic             adc_start
);
  logic armed;
  logic hit;

  assign armed = mode_armed(mode);

  ocmp_match_edge #(.TMR_W(TMR_W)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .tmr_val (tmr_val),
    .cmp_val (cmp_val),
    .arm     (armed),
    .hit     (hit)
  );

  ocmp_pin_ctl u_pin (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .hit     (hit),
    .pin_out (pin_out)
  );

  ocmp_event_gen #(.ADC_CH(ADC_CH)) u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .hit       (hit),
    .flag_clr  (flag_clr),
    .cmp_flag  (cmp_flag),
    .tmr_clr   (tmr_clr),
    .adc_start (adc_start)
  );
endmodule

// File: rtl/ocmp_unit_chk.sv
module ocmp_unit_chk #(
  parameter int TMR_W  = 16,
  parameter bit ADC_CH = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [TMR_W-1:0] tmr_val,
  input logic [TMR_W-1:0] cmp_val,
  input logic [3:0]       mode,
  input logic             flag_clr,
  input logic             pin_out,
  input logic             cmp_flag,
  input logic             tmr_clr,
  input logic             adc_start
);
  // R7: the timer clear request lasts one cycle
  assert_clr_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_clr |=> !tmr_clr);

  // R7: every timer clear request comes with the flag set
  assert_clr_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_clr |-> cmp_flag);

  // R8: the converter start follows the clear request, per build
  assert_adc_tracks_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start == (ADC_CH ? tmr_clr : 1'b0));

  // R2, R3: a new flag needs armed mode and equality in the sampled cycle
  assert_flag_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_flag) |-> ($past(tmr_val == cmp_val) && $past(mode[3:2] == 2'b10)));

  // R9: the flag clears only when the strobe is seen with no new equality
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmp_flag) |-> $past(flag_clr));

  // R4, R5, R10: the pin moves only under the set or clear modes
  assert_pin_modes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_out) |-> ($past(mode) == 4'b1000 || $past(mode) == 4'b1001));
endmodule

bind ocmp_unit ocmp_unit_chk #(.TMR_W(TMR_W), .ADC_CH(ADC_CH)) u_chk (.*);

// File: tb/tb_ocmp_unit.sv
`timescale 1ns/1ps
module tb_ocmp_unit;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] tmr_val = '0;
  logic [W-1:0] cmp_val = '0;
  logic [3:0]   mode = 4'b0000;
  logic         flag_clr = 1'b0;
  logic         pin_a, flag_a, clr_a, adc_a;
  logic         pin_b, flag_b, clr_b, adc_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference state built from the requirements
  logic m_eqq, m_pin, m_flag, m_clr;
  logic [3:0] m_modeq;

  always #2.5 clk = ~clk;

  ocmp_unit #(.TMR_W(W), .ADC_CH(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .tmr_val(tmr_val), .cmp_val(cmp_val),
    .mode(mode), .flag_clr(flag_clr), .pin_out(pin_a), .cmp_flag(flag_a),
    .tmr_clr(clr_a), .adc_start(adc_a));

  ocmp_unit #(.TMR_W(W), .ADC_CH(1'b0)) dut_b (
    .clk(clk), .rst_n(rst_n), .tmr_val(tmr_val), .cmp_val(cmp_val),
    .mode(mode), .flag_clr(flag_clr), .pin_out(pin_b), .cmp_flag(flag_b),
    .tmr_clr(clr_b), .adc_start(adc_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic armed(input logic [3:0] m);
    return m[3:2] == 2'b10;
  endfunction

  // One cycle: drive, predict, sample after the edge, compare.
  task automatic step(input logic [3:0] m, input logic [W-1:0] t,
                      input logic [W-1:0] c, input logic fc);
    logic eq, hit, ent, pin_n, flag_n, clr_n;
    @(negedge clk);
    mode = m; tmr_val = t; cmp_val = c; flag_clr = fc;
    eq  = (t == c);
    hit = armed(m) && eq && !m_eqq;
    ent = (m != m_modeq);
    pin_n = m_pin;
    if (ent && m == 4'b1000) pin_n = 1'b0;
    if (ent && m == 4'b1001) pin_n = 1'b1;
    if (hit && m == 4'b1000) pin_n = 1'b1;
    if (hit && m == 4'b1001) pin_n = 1'b0;
    flag_n = hit ? 1'b1 : (fc ? 1'b0 : m_flag);
    clr_n  = hit && (m == 4'b1011);
    @(posedge clk); #1;
    m_eqq = eq; m_modeq = m; m_pin = pin_n; m_flag = flag_n; m_clr = clr_n;
    chk("R4/R5/R10 pin", {31'd0, pin_a}, {31'd0, m_pin});
    chk("R9 flag", {31'd0, flag_a}, {31'd0, m_flag});
    chk("R7 tmr_clr", {31'd0, clr_a}, {31'd0, m_clr});
    chk("R8 adc_start ch", {31'd0, adc_a}, {31'd0, m_clr});
    chk("R8 adc_start no-ch", {31'd0, adc_b}, 32'd0);
    chk("R2 twin match", {29'd0, pin_b, flag_b, clr_b}, {29'd0, pin_a, flag_a, clr_a});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] base;
    void'($urandom(32'hC0FFEE));
    m_eqq = 0; m_pin = 0; m_flag = 0; m_clr = 0; m_modeq = 4'b0000;
    tmr_val = 16'd100; cmp_val = 16'd100; mode = 4'b1000;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset outputs", {28'd0, pin_a, flag_a, clr_a, adc_a}, 32'd0);
    @(negedge clk); mode = 4'b0000; rst_n = 1'b1;
    @(posedge clk); #1;
    m_eqq = 1'b1; m_modeq = 4'b0000;

    // Preset on entering clear-on-match
    step(4'b1000, 16'd50, 16'd100, 1'b0);
    step(4'b1001, 16'd50, 16'd100, 1'b0);
    chk("R10 preset high", {31'd0, pin_a}, 32'd1);
    step(4'b1001, 16'd100, 16'd100, 1'b0);
    chk("R5 clear on match", {30'd0, pin_a, flag_a}, 32'b01);
    step(4'b1001, 16'd100, 16'd100, 1'b1);
    chk("R3 no refire on held equality", {31'd0, flag_a}, 32'd0);
    step(4'b1000, 16'd100, 16'd100, 1'b0);
    chk("R10 preset low", {31'd0, pin_a}, 32'd0);
    step(4'b1000, 16'd101, 16'd100, 1'b0);
    step(4'b1000, 16'd100, 16'd100, 1'b1);
    chk("R4 set on match", {31'd0, pin_a}, 32'd1);
    chk("R9 match beats clear", {31'd0, flag_a}, 32'd1);
    step(4'b1010, 16'd7, 16'd100, 1'b1);
    step(4'b1010, 16'd100, 16'd100, 1'b0);
    chk("R6 flag only", {30'd0, pin_a, flag_a}, 32'b11);
    step(4'b1011, 16'd5, 16'd100, 1'b1);
    step(4'b1011, 16'd100, 16'd100, 1'b0);
    chk("R7 special event", {29'd0, clr_a, flag_a, pin_a}, 32'b111);
    chk("R8 converter start", {30'd0, adc_a, adc_b}, 32'b10);
    step(4'b1011, 16'd100, 16'd100, 1'b0);
    chk("R7 single pulse", {31'd0, clr_a}, 32'd0);
    step(4'b1100, 16'd1, 16'd100, 1'b1);
    step(4'b1100, 16'd100, 16'd100, 1'b0);
    chk("R2 unarmed code", {30'd0, flag_a, clr_a}, 32'd0);
    step(4'b0000, 16'd1, 16'd100, 1'b0);
    step(4'b0000, 16'd100, 16'd100, 1'b0);
    chk("R2 off code", {30'd0, flag_a, clr_a}, 32'd0);

    // Random traffic near the compare value
    base = 16'hFFFE;
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] m;
      m = mode;
      if (($urandom % 16) == 0) begin
        case ($urandom % 6)
          0: m = 4'b1000; 1: m = 4'b1001; 2: m = 4'b1010;
          3: m = 4'b1011; 4: m = 4'b0000; default: m = 4'($urandom);
        endcase
      end
      if (($urandom % 200) == 0) base = W'($urandom);
      step(m, base + W'($urandom % 5) - W'(2), base, ($urandom % 8) == 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule